// File: doc/BRIEF.md
# Deep Standby Wake Controller

This block takes a core into a deep low-power standby state and brings it back out. A sleep request from the processor starts the entry. For one cycle the block captures the level of every wake-capable pin: one non-maskable interrupt pin and a parameterised number of IRQ pins. It then asserts a clock-stop output. The block runs on an always-on clock. A pin can end the standby only when its enable bit is set and it has a single-edge polarity whose starting level matches the captured level. Level-sensitive and both-edge settings never wake the core.

When an armed pin reaches its target level, the block starts an oscillator-settling count of programmable length. At the end of the count it checks the pins again. Every armed pin that is still at its target level sets its own sticky cancel flag, and the block then pulses a wake indication and returns to normal running. If no armed pin remains at its target level, the event is treated as a glitch and the block goes back to standby. A manual reset also ends standby. While the block is not running, interrupt requests from sources that are not enabled for wake are masked. A sleep request that arrives in the same cycle as an interrupt request or a manual reset is aborted.

Top module: `dsw_wake_ctrl`

## Requirements
- R1: After reset the block is running: clk_stop_o, settling_o, wake_pulse_o and sleep_abort_o are 0, all cancel flags are 0, and int_req_o equals int_req_i.
- R2: A configuration write (enables, edge modes, settle length) takes effect only when cfg_we_i is high while the block is running. A write at any other time leaves the configuration unchanged.
- R3: A sleep request sampled while running, with no race, leads to one capture cycle. clk_stop_o rises on the second clock edge after the request is sampled.
- R4: If sleep_req_i is sampled while running together with any int_req_i bit or manual_rst_i, the block stays running and sleep_abort_o is high for exactly the next cycle.
- R5: While running, int_req_o equals int_req_i. In every other state, int_req_o equals int_req_i AND the enable vector.
- R6: Pin i is armed only when its enable bit is set and either its mode is 2'b01 (falling) with a captured level of 1, or its mode is 2'b10 (rising) with a captured level of 0. Mode 2'b00 (level) and mode 2'b11 (both edges) never arm a pin. Pin i's mode is cfg_edge_mode_i[2i+1:2i], and pin 0 is the non-maskable interrupt pin.
- R7: Pins pass through a two-flop synchronizer. When an armed pin's synchronized level reaches its target level during standby, settling_o goes high for settle_len+1 cycles while clk_stop_o stays high.
- R8: At the end of settling, each armed pin that is still at its target level sets its flag. wake_pulse_o is then high for one cycle and the block returns to running with clk_stop_o low. If no pin qualifies and no manual reset is pending, the block returns to standby without a pulse and without setting any flag.
- R9: Several armed pins that qualify together each set their own flag in the same cycle.
- R10: Cancel flags are sticky. Writing 1 to a bit of flag_clr_i while flag_clr_we_i is high clears that flag, and a 0 bit leaves the flag unchanged.
- R11: A sleep request is accepted even when no source is enabled. The block then stays in standby until manual_rst_i is asserted, and after settling it wakes with the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req_i | input | 1 | Deep standby request from the sleep instruction |
| manual_rst_i | input | 1 | Manual reset event |
| wake_pin_i | input | N_SRC | Asynchronous wake pin levels, bit 0 is the non-maskable interrupt pin |
| int_req_i | input | N_SRC | Interrupt requests from the pin logic |
| int_req_o | output | N_SRC | Interrupt requests after standby masking |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_en_i | input | N_SRC | Wake source enable per pin |
| cfg_edge_mode_i | input | 2*N_SRC | Edge mode per pin, 2 bits each |
| cfg_settle_len_i | input | SETTLE_W | Oscillator settling count |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_i | input | N_SRC | Write-1-to-clear mask for the flags |
| cancel_flags_o | output | N_SRC | Sticky cancel-source flags |
| clk_stop_o | output | 1 | Clock stopped (standby or settling) |
| settling_o | output | 1 | Oscillator settling in progress |
| wake_pulse_o | output | 1 | One-cycle wake indication |
| sleep_abort_o | output | 1 | One-cycle pulse when a sleep request was aborted by a race |

## Verification
The bench targets a pin that drops to its target level and comes back before settling ends. A design that decided the wake on the first edge would wake and set a flag here, when it should fall back to standby. It also checks pins whose level at capture rules out their edge, and pins set to level or both-edge mode. A design that ignored the captured level or the mode encoding would wake on these. Sleep requests that coincide with an interrupt or a manual reset are issued, and a wrong design would stop the clock instead of pulsing the abort output. The bench also attempts configuration writes during standby, which a design with an ungated write would accept. It writes zeros to the flag clear, which a design that treated the write as a plain store would use to wipe the flags.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_ENTER  = 3'd1,
    ST_STBY   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_WDONE  = 3'd4
  } dsw_state_e;

  localparam logic [1:0] EDGE_LEVEL = 2'b00;
  localparam logic [1:0] EDGE_FALL  = 2'b01;
  localparam logic [1:0] EDGE_RISE  = 2'b10;
  localparam logic [1:0] EDGE_BOTH  = 2'b11;

endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/dsw_cfg.sv
module dsw_cfg #(
  parameter int N_SRC    = 5,
  parameter int SETTLE_W = 8,
  localparam int MODE_W  = 2 * N_SRC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [N_SRC-1:0]    en_wdata_i,
  input  logic [MODE_W-1:0]   mode_wdata_i,
  input  logic [SETTLE_W-1:0] settle_wdata_i,
  output logic [N_SRC-1:0]    en_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [SETTLE_W-1:0] settle_o
);

  logic [N_SRC-1:0]    en_q,     en_d;
  logic [MODE_W-1:0]   mode_q,   mode_d;
  logic [SETTLE_W-1:0] settle_q, settle_d;

  always_comb begin
    en_d     = en_q;
    mode_d   = mode_q;
    settle_d = settle_q;
    if (wr_en_i) begin
      en_d     = en_wdata_i;
      mode_d   = mode_wdata_i;
      settle_d = settle_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      mode_q   <= '0;
      settle_q <= '0;
    end else if (wr_en_i) begin
      en_q     <= en_d;
      mode_q   <= mode_d;
      settle_q <= settle_d;
    end
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign settle_o = settle_q;

endmodule

// File: rtl/dsw_edge.sv
module dsw_edge
  import dsw_pkg::*;
#(
  parameter int N_SRC   = 5,
  localparam int MODE_W = 2 * N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [N_SRC-1:0]  level_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [N_SRC-1:0]  armed_o,
  output logic [N_SRC-1:0]  at_target_o
);

  logic [N_SRC-1:0] lat_q;

  // Level captured as the clock stops; reference for every later edge test.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (capture_i) begin
      lat_q <= level_i;
    end
  end

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_pin
    logic [1:0] pin_mode;
    logic       pin_armed;
    logic       pin_target;

    assign pin_mode = mode_i[2*gi +: 2];

    always_comb begin
      pin_armed  = 1'b0;
      pin_target = 1'b0;
      unique case (pin_mode)
        EDGE_FALL: begin
          pin_armed  = lat_q[gi];
          pin_target = ~level_i[gi];
        end
        EDGE_RISE: begin
          pin_armed  = ~lat_q[gi];
          pin_target = level_i[gi];
        end
        EDGE_LEVEL: pin_armed = 1'b0;
        EDGE_BOTH:  pin_armed = 1'b0;
        default:    pin_armed = 1'b0;
      endcase
    end

    assign armed_o[gi]     = en_i[gi] & pin_armed;
    assign at_target_o[gi] = en_i[gi] & pin_armed & pin_target;
  end

endmodule

// File: rtl/dsw_flags.sv
module dsw_flags #(
  parameter int N_SRC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [N_SRC-1:0] set_vec_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_vec_i,
  output logic [N_SRC-1:0] flags_o
);

  logic [N_SRC-1:0] flags_q, flags_d;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] set_mask;
  logic             upd_en;

  always_comb begin
    clr_mask = clr_we_i ? clr_vec_i : '0;
    set_mask = set_en_i ? set_vec_i : '0;
    flags_d  = (flags_q & ~clr_mask) | set_mask;
    upd_en   = clr_we_i | set_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic                race_i,
  input  logic                mrst_i,
  input  logic                hit_any_i,
  input  logic [SETTLE_W-1:0] settle_len_i,
  output dsw_state_e          state_o,
  output logic                capture_o,
  output logic                flag_set_o,
  output logic                abort_o
);

  dsw_state_e          state_q, state_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;
  logic                pend_q, pend_d;
  logic                abort_q, abort_d;
  logic                cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    pend_d     = pend_q;
    abort_d    = 1'b0;
    capture_o  = 1'b0;
    flag_set_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        pend_d = 1'b0;
        if (sleep_req_i) begin
          if (race_i) abort_d = 1'b1;
          else        state_d = ST_ENTER;
        end
      end
      ST_ENTER: begin
        capture_o = 1'b1;
        if (mrst_i) pend_d = 1'b1;
        state_d = ST_STBY;
      end
      ST_STBY: begin
        if (mrst_i) pend_d = 1'b1;
        if (hit_any_i || mrst_i || pend_q) begin
          state_d = ST_SETTLE;
          cnt_d   = settle_len_i;
          cnt_en  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (mrst_i) pend_d = 1'b1;
        if (cnt_zero) begin
          if (hit_any_i || pend_q || mrst_i) begin
            flag_set_o = 1'b1;
            state_d    = ST_WDONE;
          end else begin
            state_d = ST_STBY;
          end
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_WDONE: begin
        pend_d  = 1'b0;
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign abort_o = abort_q;

endmodule

// File: rtl/dsw_wake_ctrl.sv
module dsw_wake_ctrl
  import dsw_pkg::*;
#(
  parameter int  N_IRQ    = 4,
  parameter int  SETTLE_W = 8,
  localparam int N_SRC    = N_IRQ + 1,
  localparam int MODE_W   = 2 * N_SRC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic                manual_rst_i,
  input  logic [N_SRC-1:0]    wake_pin_i,
  input  logic [N_SRC-1:0]    int_req_i,
  output logic [N_SRC-1:0]    int_req_o,
  input  logic                cfg_we_i,
  input  logic [N_SRC-1:0]    cfg_src_en_i,
  input  logic [MODE_W-1:0]   cfg_edge_mode_i,
  input  logic [SETTLE_W-1:0] cfg_settle_len_i,
  input  logic                flag_clr_we_i,
  input  logic [N_SRC-1:0]    flag_clr_i,
  output logic [N_SRC-1:0]    cancel_flags_o,
  output logic                clk_stop_o,
  output logic                settling_o,
  output logic                wake_pulse_o,
  output logic                sleep_abort_o
);

  logic rst_meta_q, rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  dsw_state_e          state_w;
  logic                run_w;
  logic                capture_w;
  logic                flag_set_w;
  logic [N_SRC-1:0]    pin_sync_w;
  logic [N_SRC-1:0]    cfg_en_q;
  logic [MODE_W-1:0]   cfg_mode_q;
  logic [SETTLE_W-1:0] cfg_settle_q;
  logic [N_SRC-1:0]    armed_w;
  logic [N_SRC-1:0]    hits_w;
  logic                race_w;

  assign run_w  = (state_w == ST_RUN);
  assign race_w = (|int_req_i) | manual_rst_i;

  dsw_sync #(.W(N_SRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .async_i (wake_pin_i),
    .sync_o  (pin_sync_w)
  );

  dsw_cfg #(.N_SRC(N_SRC), .SETTLE_W(SETTLE_W)) u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_s),
    .wr_en_i        (cfg_we_i & run_w),
    .en_wdata_i     (cfg_src_en_i),
    .mode_wdata_i   (cfg_edge_mode_i),
    .settle_wdata_i (cfg_settle_len_i),
    .en_o           (cfg_en_q),
    .mode_o         (cfg_mode_q),
    .settle_o       (cfg_settle_q)
  );

  dsw_edge #(.N_SRC(N_SRC)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .capture_i   (capture_w),
    .level_i     (pin_sync_w),
    .en_i        (cfg_en_q),
    .mode_i      (cfg_mode_q),
    .armed_o     (armed_w),
    .at_target_o (hits_w)
  );

  dsw_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .sleep_req_i  (sleep_req_i),
    .race_i       (race_w),
    .mrst_i       (manual_rst_i),
    .hit_any_i    (|hits_w),
    .settle_len_i (cfg_settle_q),
    .state_o      (state_w),
    .capture_o    (capture_w),
    .flag_set_o   (flag_set_w),
    .abort_o      (sleep_abort_o)
  );

  dsw_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .set_en_i  (flag_set_w),
    .set_vec_i (hits_w & armed_w),
    .clr_we_i  (flag_clr_we_i),
    .clr_vec_i (flag_clr_i),
    .flags_o   (cancel_flags_o)
  );

  assign int_req_o    = run_w ? int_req_i : (int_req_i & cfg_en_q);
  assign clk_stop_o   = (state_w == ST_STBY) || (state_w == ST_SETTLE);
  assign settling_o   = (state_w == ST_SETTLE);
  assign wake_pulse_o = (state_w == ST_WDONE);

endmodule

// File: rtl/dsw_wake_ctrl_chk.sv
module dsw_wake_ctrl_chk #(
  parameter int N_SRC = 5
) (
  input logic             clk_i,
  input logic             rst_n_s,
  input logic             run_w,
  input logic             sleep_req_i,
  input logic             manual_rst_i,
  input logic [N_SRC-1:0] int_req_i,
  input logic [N_SRC-1:0] int_req_o,
  input logic [N_SRC-1:0] cfg_en_q,
  input logic [N_SRC-1:0] cancel_flags_o,
  input logic             clk_stop_o,
  input logic             settling_o,
  input logic             wake_pulse_o,
  input logic             sleep_abort_o
);

  assert_cfg_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !run_w |=> $stable(cfg_en_q));

  assert_race_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (run_w && sleep_req_i && ((|int_req_i) || manual_rst_i)) |=> (sleep_abort_o && !clk_stop_o));

  assert_mask_subset_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (int_req_o & ~int_req_i) == '0);

  assert_mask_standby_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !run_w |-> ((int_req_o & ~cfg_en_q) == '0));

  assert_flag_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ((cancel_flags_o & ~$past(cancel_flags_o) & ~$past(cfg_en_q)) == '0));

  assert_settle_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    settling_o |-> clk_stop_o);

  assert_flag_after_settle_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ((cancel_flags_o & ~$past(cancel_flags_o)) != '0) |-> $past(settling_o));

  assert_wake_single_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wake_pulse_o |=> (!wake_pulse_o && !clk_stop_o));

  assert_exit_via_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(clk_stop_o) |-> wake_pulse_o);

endmodule

bind dsw_wake_ctrl dsw_wake_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i          (clk_i),
  .rst_n_s        (rst_n_s),
  .run_w          (run_w),
  .sleep_req_i    (sleep_req_i),
  .manual_rst_i   (manual_rst_i),
  .int_req_i      (int_req_i),
  .int_req_o      (int_req_o),
  .cfg_en_q       (cfg_en_q),
  .cancel_flags_o (cancel_flags_o),
  .clk_stop_o     (clk_stop_o),
  .settling_o     (settling_o),
  .wake_pulse_o   (wake_pulse_o),
  .sleep_abort_o  (sleep_abort_o)
);

// File: tb/dsw_wake_ctrl_bench.sv
`timescale 1ns/1ps
module dsw_wake_ctrl_bench;
  localparam int N_IRQ = 4;
  localparam int N_SRC = N_IRQ + 1;
  localparam int SW    = 8;
  localparam int MW    = 2 * N_SRC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             sleep_req, manual_rst, cfg_we, flag_clr_we;
  logic [N_SRC-1:0] pins, int_req, int_out, cfg_en, flag_clr, flags;
  logic [MW-1:0]    cfg_mode;
  logic [SW-1:0]    cfg_settle;
  logic             clk_stop, settling, wake_pulse, sleep_abort;

  dsw_wake_ctrl #(.N_IRQ(N_IRQ), .SETTLE_W(SW)) u_dsw_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .manual_rst_i(manual_rst),
    .wake_pin_i(pins), .int_req_i(int_req), .int_req_o(int_out),
    .cfg_we_i(cfg_we), .cfg_src_en_i(cfg_en), .cfg_edge_mode_i(cfg_mode),
    .cfg_settle_len_i(cfg_settle), .flag_clr_we_i(flag_clr_we), .flag_clr_i(flag_clr),
    .cancel_flags_o(flags), .clk_stop_o(clk_stop), .settling_o(settling),
    .wake_pulse_o(wake_pulse), .sleep_abort_o(sleep_abort)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N_SRC-1:0] exp_hits(input logic [N_SRC-1:0] en, input logic [MW-1:0] mode,
                                                input logic [N_SRC-1:0] lat, input logic [N_SRC-1:0] now);
    logic [N_SRC-1:0] r = '0;
    for (int i = 0; i < N_SRC; i++) begin
      logic [1:0] m = mode[2*i +: 2];
      if (en[i] && ((m == 2'b01 && lat[i] && !now[i]) || (m == 2'b10 && !lat[i] && now[i])))
        r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic do_cfg(input logic [N_SRC-1:0] en, input logic [MW-1:0] mode, input logic [SW-1:0] st);
    cfg_en = en; cfg_mode = mode; cfg_settle = st; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_pins(input logic [N_SRC-1:0] v);
    pins = v;
    repeat (4) step();
  endtask

  task automatic clear_flags();
    flag_clr = '1; flag_clr_we = 1'b1;
    step();
    flag_clr_we = 1'b0; flag_clr = '0;
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R3", "clk_stop one edge after request", {31'd0, clk_stop}, 32'd0);
    step();
    chk("R3", "clk_stop two edges after request", {31'd0, clk_stop}, 32'd1);
  endtask

  task automatic wait_wake(input int lim, output bit got, output int nset);
    got = 1'b0; nset = 0;
    for (int k = 0; k < lim && !got; k++) begin
      step();
      if (settling) nset++;
      if (wake_pulse) got = 1'b1;
    end
  endtask

  task automatic after_wake();
    step();
    chk("R8", "wake pulse single cycle", {31'd0, wake_pulse}, 32'd0);
    chk("R8", "clock running after wake", {31'd0, clk_stop}, 32'd0);
  endtask

  task automatic mrst_pulse();
    manual_rst = 1'b1;
    step();
    manual_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    int nset;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; sleep_req = 0; manual_rst = 0; cfg_we = 0; flag_clr_we = 0;
    pins = '0; int_req = '0; cfg_en = '0; flag_clr = '0; cfg_mode = '0; cfg_settle = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1", "clk_stop", {31'd0, clk_stop}, 32'd0);
    chk("R1", "settling", {31'd0, settling}, 32'd0);
    chk("R1", "wake_pulse", {31'd0, wake_pulse}, 32'd0);
    chk("R1", "sleep_abort", {31'd0, sleep_abort}, 32'd0);
    chk("R1", "flags", {27'd0, flags}, 32'd0);
    int_req = 5'h15;
    #0.1;
    chk("R5", "run pass-through", {27'd0, int_out}, 32'h15);
    int_req = '0;

    // R4 race with interrupt request
    int_req = 5'h04; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0; int_req = '0;
    chk("R4", "abort pulse on irq race", {31'd0, sleep_abort}, 32'd1);
    chk("R4", "no clock stop on irq race", {31'd0, clk_stop}, 32'd0);
    step();
    chk("R4", "abort single cycle", {31'd0, sleep_abort}, 32'd0);
    chk("R4", "still running", {31'd0, clk_stop}, 32'd0);
    // R4 race with manual reset
    manual_rst = 1'b1; sleep_req = 1'b1;
    step();
    manual_rst = 1'b0; sleep_req = 1'b0;
    chk("R4", "abort pulse on manual reset race", {31'd0, sleep_abort}, 32'd1);
    step();
    chk("R4", "running after manual reset race", {31'd0, clk_stop}, 32'd0);

    // R7 settling length, NMI falling edge
    do_cfg(5'h01, 10'h001, 8'd5);
    set_pins(5'h01);
    clear_flags();
    enter_sleep();
    pins = 5'h00;
    wait_wake(40, got, nset);
    chk("R8", "NMI falling wake", {31'd0, got}, 32'd1);
    chk("R7", "settling cycles", nset, 32'd6);
    chk("R8", "NMI flag", {27'd0, flags}, 32'h01);
    after_wake();

    // R8 glitch: pin returns before settling ends
    do_cfg(5'h01, 10'h001, 8'd20);
    set_pins(5'h01);
    clear_flags();
    enter_sleep();
    pins = 5'h00;
    repeat (3) step();
    pins = 5'h01;
    wait_wake(40, got, nset);
    chk("R8", "glitch no wake", {31'd0, got}, 32'd0);
    chk("R8", "glitch back to standby", {31'd0, clk_stop}, 32'd1);
    chk("R8", "glitch no flag", {27'd0, flags}, 32'd0);
    mrst_pulse();
    wait_wake(40, got, nset);
    chk("R11", "manual reset exits", {31'd0, got}, 32'd1);
    chk("R11", "manual reset leaves flags", {27'd0, flags}, 32'd0);
    after_wake();

    // R9 several sources at once, then R10 write-1-to-clear
    do_cfg(5'h07, 10'h019, 8'd3);
    set_pins(5'h05);
    clear_flags();
    enter_sleep();
    pins = 5'h02;
    wait_wake(40, got, nset);
    chk("R9", "multi wake", {31'd0, got}, 32'd1);
    chk("R9", "three flags together", {27'd0, flags}, 32'h07);
    after_wake();
    flag_clr = 5'h00; flag_clr_we = 1'b1; step(); flag_clr_we = 1'b0;
    chk("R10", "write zero keeps flags", {27'd0, flags}, 32'h07);
    flag_clr = 5'h02; flag_clr_we = 1'b1; step(); flag_clr_we = 1'b0; flag_clr = '0;
    chk("R10", "write one clears bit", {27'd0, flags}, 32'h05);
    step();
    chk("R10", "flags sticky", {27'd0, flags}, 32'h05);

    // R6 level, both-edge and wrongly latched pins never wake
    do_cfg(5'h1C, 10'h310, 8'd2);
    set_pins(5'h00);
    clear_flags();
    enter_sleep();
    pins = 5'h1C;
    wait_wake(15, got, nset);
    chk("R6", "no wake on rise for level/both/fall", {31'd0, got}, 32'd0);
    pins = 5'h00;
    wait_wake(15, got, nset);
    chk("R6", "no wake on fall for level/both/unarmed", {31'd0, got}, 32'd0);
    chk("R6", "still standby", {31'd0, clk_stop}, 32'd1);
    mrst_pulse();
    wait_wake(20, got, nset);
    chk("R6", "exit by manual reset", {31'd0, got}, 32'd1);
    chk("R6", "no flags set", {27'd0, flags}, 32'd0);
    after_wake();

    // R11 no source enabled; R2 config write during standby ignored
    do_cfg(5'h00, 10'h000, 8'd4);
    set_pins(5'h00);
    enter_sleep();
    do_cfg(5'h1F, 10'h2AA, 8'd0);
    pins = 5'h1F;
    wait_wake(20, got, nset);
    chk("R2", "standby config write ignored", {31'd0, got}, 32'd0);
    chk("R11", "standby held without sources", {31'd0, clk_stop}, 32'd1);
    int_req = 5'h1F;
    #0.1;
    chk("R5", "all masked with no sources", {27'd0, int_out}, 32'd0);
    int_req = '0;
    mrst_pulse();
    wait_wake(20, got, nset);
    chk("R11", "manual reset wakes", {31'd0, got}, 32'd1);
    chk("R11", "flags untouched", {27'd0, flags}, 32'd0);
    after_wake();

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [N_SRC-1:0] en, lat, now, irq, hits;
      logic [MW-1:0]    mode;
      logic [SW-1:0]    st;
      en = N_SRC'($urandom); mode = MW'($urandom); st = SW'($urandom_range(0, 7));
      lat = N_SRC'($urandom); now = N_SRC'($urandom); irq = N_SRC'($urandom);
      do_cfg(en, mode, st);
      set_pins(lat);
      clear_flags();
      enter_sleep();
      int_req = irq;
      #0.1;
      chk("R5", "random standby mask", {27'd0, int_out}, {27'd0, irq & en});
      int_req = '0;
      do_cfg(~en, ~mode, 8'd0);
      hits = exp_hits(en, mode, lat, now);
      pins = now;
      wait_wake(30, got, nset);
      if (hits != '0) begin
        chk("R8", "random wake", {31'd0, got}, 32'd1);
        chk("R9", "random flags", {27'd0, flags}, {27'd0, hits});
        chk("R7", "random settle length", nset, {24'd0, st} + 32'd1);
      end else begin
        chk("R6", "random no wake", {31'd0, got}, 32'd0);
        chk("R6", "random still standby", {31'd0, clk_stop}, 32'd1);
        mrst_pulse();
        wait_wake(30, got, nset);
        chk("R11", "random manual exit", {31'd0, got}, 32'd1);
        chk("R11", "random no flags", {27'd0, flags}, 32'd0);
      end
      after_wake();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule